// File: doc/BRIEF.md
# Timer Channel Interrupt Status and Mask

This block holds the interrupt state for a bank of timer channels. Each channel has one pending bit and one mask bit. The channel engine reports an event as a one-cycle pulse together with a channel number, and that sets the channel's pending bit. The host sees two registers of `NUM_CHAN` bits each, and bit n in both registers belongs to channel n. The first register holds the enable mask and is plain read/write. The second holds the pending flags, and the host clears them by writing zero.

A pending bit is cleared only when the host writes a 0 to it. Bits written as 1 keep their value. So one store of a word that is all ones except a single zero clears exactly one channel and leaves the others as they are. This lets independent service routines clear their own channels without a read-modify-write race. The block drives a single interrupt request line, taken from a flop. It is high whenever at least one channel is both pending and enabled.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0, the status register reads 0 and `irq_o` is low.
- R2: A write with `wr_sel_i`=0 loads `wr_data_i` into the enable register, and the value reads back with `rd_sel_i`=0 after the next clock edge. Bit n is channel n.
- R3: An event pulse (`evt_valid_i`=1) sets status bit `evt_chan_i` at the next clock edge, whatever the enable bits hold.
- R4: A write with `wr_sel_i`=1 clears each status bit where the data bit is 0 and leaves each status bit where the data bit is 1 unchanged. For example, writing 0xFFFE clears only channel 0.
- R5: If an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq_o` is high one cycle after the status register AND the enable register is nonzero, and low one cycle after it is zero. A pending channel whose enable bit is 0 does not raise `irq_o`.
- R7: `rd_data_o` shows the enable register when `rd_sel_i`=0 and the status register when `rd_sel_i`=1. It is combinational, and reading changes no state.
- R8: A write to one register leaves the other unchanged. With no event and no status write, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 status |
| wr_data_i | input | 16 | Host write data |
| rd_sel_i | input | 1 | Read source: 0 enable, 1 status |
| rd_data_o | output | 16 | Read data of the selected register |
| evt_valid_i | input | 1 | Channel event pulse |
| evt_chan_i | input | 4 | Channel number of the event |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
A write or an event presented in cycle k changes a register at edge k. The readback port is combinational, so the new value is visible right after that edge. `irq_o` passes through one more flop, so it follows the register contents of cycle k at edge k+1. The bench drives inputs on the falling edge. A few time units after each rising edge it updates its model in the same order: the request is taken from the old contents, then the registers are updated. It then reads both registers and the request line and compares them with the model, so each result is sampled in the cycle it is due.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_CHAN-1:0] wdata_i,
  output logic [NUM_CHAN-1:0] en_o
);
  logic [NUM_CHAN-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q)); // R8
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter  int NUM_CHAN = 16,
  localparam int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_we_i,
  input  logic [NUM_CHAN-1:0] clr_mask_i,  // 0 = clear, 1 = keep
  input  logic                evt_valid_i,
  input  logic [CHAN_W-1:0]   evt_chan_i,
  output logic [NUM_CHAN-1:0] status_o
);
  logic [NUM_CHAN-1:0] status_q;
  logic [NUM_CHAN-1:0] set_vec;
  logic [NUM_CHAN-1:0] keep_vec;

  // per-bit update: set dominates clear
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_bit
    assign set_vec[i]  = evt_valid_i && (evt_chan_i == CHAN_W'(i));
    assign keep_vec[i] = !clr_we_i || clr_mask_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else         status_q[i] <= set_vec[i] | (status_q[i] & keep_vec[i]);
    end

    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_valid_i && evt_chan_i == CHAN_W'(i)) |=> status_q[i]); // R5
  end

  assign status_o = status_q;

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> (status_q & ~$past(status_q)) == '0); // R3
  AST_ONES_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_i && (!clr_we_i || &clr_mask_i)) |=> $stable(status_q)); // R4
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CHAN-1:0] status_i,
  input  logic [NUM_CHAN-1:0] en_i,
  output logic                irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl #(
  parameter  int NUM_CHAN = 16,
  localparam int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [NUM_CHAN-1:0] wr_data_i,
  input  logic                rd_sel_i,
  output logic [NUM_CHAN-1:0] rd_data_o,
  input  logic                evt_valid_i,
  input  logic [CHAN_W-1:0]   evt_chan_i,
  output logic                irq_o
);
  import chan_irq_pkg::*;

  reg_sel_e            wsel, rsel;
  logic [NUM_CHAN-1:0] en_w, status_w;
  logic                we_en, we_st;

  assign wsel  = reg_sel_e'(wr_sel_i);
  assign rsel  = reg_sel_e'(rd_sel_i);
  assign we_en = wr_en_i && (wsel == SEL_ENABLE);
  assign we_st = wr_en_i && (wsel == SEL_STATUS);

  irq_enable_reg #(.NUM_CHAN(NUM_CHAN)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_en),
    .wdata_i(wr_data_i),
    .en_o   (en_w)
  );

  irq_status_reg #(.NUM_CHAN(NUM_CHAN)) u_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (we_st),
    .clr_mask_i (wr_data_i),
    .evt_valid_i(evt_valid_i),
    .evt_chan_i (evt_chan_i),
    .status_o   (status_w)
  );

  irq_req_gen #(.NUM_CHAN(NUM_CHAN)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_w),
    .en_i    (en_w),
    .irq_o   (irq_o)
  );

  assign rd_data_o = (rsel == SEL_STATUS) ? status_w : en_w;

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & en_w) == '0) |=> !irq_o); // R6
  AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & en_w) != '0) |=> irq_o); // R6
  AST_EN_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_en |=> en_w == $past(wr_data_i)); // R2
  AST_ST_IGNORES_EN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_en && !evt_valid_i) |=> $stable(status_w)); // R8
endmodule

// File: tb/chan_irq_ctrl_bench.sv
module chan_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [N-1:0]  wr_data = '0;
  logic [N-1:0]  rd_data;
  logic          evt_valid = 1'b0;
  logic [3:0]    evt_chan = '0;
  logic          irq;

  logic [N-1:0]  en_m = '0, st_m = '0;
  logic          irq_m = 1'b0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_ctrl #(.NUM_CHAN(N)) u_chan_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .evt_valid_i(evt_valid), .evt_chan_i(evt_chan), .irq_o(irq)
  );

  function automatic logic [N-1:0] next_status(logic [N-1:0] s, logic w, logic sel,
                                               logic [N-1:0] d, logic ev, logic [3:0] ch);
    logic [N-1:0] r = s;
    if (w && sel) r = r & d;
    if (ev) r[ch] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] next_enable(logic [N-1:0] e, logic w, logic sel,
                                               logic [N-1:0] d);
    return (w && !sel) ? d : e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string te, input string ts, input string ti);
    rd_sel = 1'b0; #1;
    chk(te, 32'(rd_data), 32'(en_m));
    rd_sel = 1'b1; #1;
    chk(ts, 32'(rd_data), 32'(st_m));
    chk(ti, 32'(irq), 32'(irq_m));
  endtask

  task automatic step(input logic w, input logic sel, input logic [N-1:0] d,
                      input logic ev, input logic [3:0] ch,
                      input string te, input string ts, input string ti);
    @(negedge clk);
    wr_en = w; wr_sel = sel; wr_data = d; evt_valid = ev; evt_chan = ch;
    @(posedge clk);
    irq_m = |(st_m & en_m);
    st_m  = next_status(st_m, w, sel, d, ev, ch);
    en_m  = next_enable(en_m, w, sel, d);
    #1;
    check_all(te, ts, ti);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    check_all("R1 enable", "R1 status", "R1 irq");
    rst_ni = 1'b1;

    // R2: enable write, bit n = channel n
    step(1, 0, 16'h00ff, 0, 0, "R2 en", "R8 st", "R6 irq");
    // R3: events set status regardless of enable (ch 12 masked)
    step(0, 0, 0, 1, 4'd12, "R8 en", "R3 st", "R6 irq");
    step(0, 0, 0, 1, 4'd0,  "R8 en", "R3 st", "R6 masked");
    step(0, 0, 0, 1, 4'd3,  "R8 en", "R3 st", "R6 raised");
    // R7: idle reads cause no change
    step(0, 0, 0, 0, 0, "R7 en", "R7 st", "R6 irq");
    step(0, 0, 0, 0, 0, "R7 en", "R7 st", "R6 irq");
    // R4: 0xFFFE clears only channel 0
    step(1, 1, 16'hfffe, 0, 0, "R8 en", "R4 st", "R6 irq");
    // R4: all ones keep everything
    step(1, 1, 16'hffff, 0, 0, "R8 en", "R4 st", "R6 irq");
    // R5: clear and set on same bit, set wins
    step(1, 1, 16'hfff7, 1, 4'd3, "R8 en", "R5 st", "R6 irq");
    // R6: mask all, irq drops one cycle later
    step(1, 0, 16'h0000, 0, 0, "R2 en", "R8 st", "R6 irq");
    step(0, 0, 0, 0, 0, "R2 en", "R8 st", "R6 low");
    // unmask masked pending channel 12
    step(1, 0, 16'h1000, 0, 0, "R2 en", "R8 st", "R6 irq");
    step(0, 0, 0, 0, 0, "R2 en", "R8 st", "R6 high");
    // clear all
    step(1, 1, 16'h0000, 0, 0, "R8 en", "R4 st", "R6 irq");
    step(0, 0, 0, 0, 0, "R8 en", "R4 st", "R6 low");

    for (int i = 0; i < 600; i++) begin
      logic          w   = ($urandom % 3) == 0;
      logic          sel = $urandom % 2;
      logic [N-1:0]  d   = ($urandom % 4 == 0) ? ~(N'(1) << ($urandom % N)) : N'($urandom);
      logic          ev  = ($urandom % 2) == 0;
      logic [3:0]    ch  = 4'($urandom);
      step(w, sel, d, ev, ch, "R2/R8 en", "R3/R4/R5 st", "R6 irq");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule